// File: doc/BRIEF.md
# Masked interrupt status register

This block gathers event indications from the transmit, receive, tone-detect, ring-detect and programming logic of a line modem. It holds them in a 16-bit status word and drives one active-low interrupt request pin. Each event sets a sticky flag. Each flag is cleared by its own bus access, which is one of these: a status read, a receive-data read, a write to either transmit-data address, or a write to the programming register. Six mask bits sit in a general control register. Each mask bit gates a group of flags into a summary interrupt bit.

The control register also holds an enable for the interrupt pin, a soft-reset bit and a powerup bit. While soft reset is set, or while powerup is clear, the status word is held cleared, apart from the ring flag. The transmit and receive mode registers are also held at zero. A one-cycle general reset strobe clears the control register as well, which leaves the block in powersave.

The modem datapaths stay outside this block. Their results arrive as single-cycle strobes on `evt_i`. The framing, parity and quality fields arrive on `fld_i` with a load strobe.

Top module: `irq_stat_top`

## Requirements
- R1: Status bit 15 is the summary flag. It is set in the cycle after any flag in bits 14..5 is set while that flag's mask bit is 1. It stays set until a status read, and a read clears it only when no masked flag is still set.
- R2: The mask groups are as follows. Mask 0 gates bits 6 and 5, mask 1 gates bits 9..7, mask 2 gates bit 10, mask 3 gates bits 12 and 11, mask 4 gates bit 13 and mask 5 gates bit 14. A flag whose mask is 0 still shows in the status word but does not set bit 15.
- R3: `irq_n_o` is driven 0 while bit 15 and the pin enable (control bit 6) are both 1. Otherwise it is high impedance.
- R4: Bits 12 (transmit ready) and 11 (transmit underflow) are cleared by a write to either transmit-data address. A status read does not clear them.
- R5: Bits 6 (receive ready) and 5 (receive overflow) are cleared by a receive-data read. A status read does not clear them.
- R6: Bit 14 (ring) and bits 10..7 (energy, pattern, continuous 0s/1s) are cleared by a status read.
- R7: Bit 13 (programming done) is cleared by a write to the programming register. A status read does not clear it.
- R8: Bits 4..0 load from `fld_i` on `fld_we_i` and stay until the next load. These bits never set bit 15 or drive the pin.
- R9: The hold condition is any of three things: control bit 7 (soft reset) is 1, control bit 8 (powerup) is 0, or `gen_rst_i` is pulsed. While the hold condition is true, status bits 15 and 13..0 and both mode registers are cleared on each clock edge. Bit 14 keeps its state.
- R10: An event strobe in the same cycle as an access that would clear its flag leaves the flag set.
- R11: The summary flag is re-evaluated every cycle. Enabling a mask bit while a flag in its group is already set raises bit 15 on the following edge.
- R12: A control write stores `wdata_i[8:0]`, and `ctl_o` reads 0 in bits 15..9. `gen_rst_i` clears the control register. The event lanes map as `evt_i[k]` to status bit k+5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gen_rst_i | input | 1 | General reset strobe |
| ctl_wr_i | input | 1 | Write strobe for the general control register |
| txm_wr_i | input | 1 | Write strobe for the transmit mode register |
| rxm_wr_i | input | 1 | Write strobe for the receive mode register |
| wdata_i | input | 16 | Bus write data |
| stat_rd_i | input | 1 | Status read strobe |
| rxd_rd_i | input | 1 | Receive-data read strobe |
| txd_wr_i | input | 1 | Transmit-data write strobe, normal address |
| txd_alt_wr_i | input | 1 | Transmit-data write strobe, alternate address |
| prog_wr_i | input | 1 | Programming register write strobe |
| evt_i | input | 10 | Event strobes; lane k sets status bit k+5 |
| fld_we_i | input | 1 | Load strobe for the status fields |
| fld_i | input | 5 | Framing, parity and quality field values |
| ctl_o | output | 16 | General control register readback |
| txm_o | output | 16 | Transmit mode register |
| rxm_o | output | 16 | Receive mode register |
| stat_o | output | 16 | Status word |
| irq_n_o | output | 1 | Interrupt request pin, active low, otherwise high impedance |

## Verification
The bench builds the block with its default parameters: a 16-bit word, ten event lanes, five field bits and six mask bits. With these values every mask group and every clearing source can be reached from the ports. The sequences aim at the interactions between groups. These are a status read that leaves the summary flag up because a receive or transmit flag is still pending, an event that coincides with its own clearing access, and a mask enabled after its flag is already set. The sequences also check that the ring flag survives a soft-reset hold while every other flag and both mode registers are cleared.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int STAT_W   = 16;
  localparam int IRQ_BIT  = 15;
  localparam int RING_BIT = 14;
  localparam int FLAG_LO  = 5;
  localparam int FLAG_HI  = 14;
  localparam int N_EVT    = FLAG_HI - FLAG_LO + 1;
  localparam int FLD_W    = FLAG_LO;
  localparam int N_MASK   = 6;
  localparam int OE_BIT   = N_MASK;
  localparam int RST_BIT  = N_MASK + 1;
  localparam int PWR_BIT  = N_MASK + 2;
  localparam int CTL_W    = PWR_BIT + 1;

  typedef enum logic [1:0] {
    CLR_ON_STAT,
    CLR_ON_RXD,
    CLR_ON_TXD,
    CLR_ON_PROG
  } clr_src_e;

  function automatic clr_src_e clr_src(input int b);
    case (b)
      5, 6:    return CLR_ON_RXD;
      11, 12:  return CLR_ON_TXD;
      13:      return CLR_ON_PROG;
      default: return CLR_ON_STAT;
    endcase
  endfunction

  function automatic int mask_sel(input int b);
    case (b)
      5, 6:    return 0;
      7, 8, 9: return 1;
      10:      return 2;
      11, 12:  return 3;
      13:      return 4;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_stat_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gen_rst_i,
  input  logic              ctl_wr_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic              txm_wr_i,
  input  logic              rxm_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CTL_W-1:0]  ctl_q_o,
  output logic [DATA_W-1:0] txm_q_o,
  output logic [DATA_W-1:0] rxm_q_o,
  output logic              hold_o
);
  logic [CTL_W-1:0]  ctl_q;
  logic [DATA_W-1:0] txm_q, rxm_q;

  assign hold_o = gen_rst_i | ctl_q[RST_BIT] | ~ctl_q[PWR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctl_q <= '0;
    else if (gen_rst_i) ctl_q <= '0;
    else if (ctl_wr_i)  ctl_q <= ctl_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txm_q <= '0;
      rxm_q <= '0;
    end else if (hold_o) begin
      txm_q <= '0;
      rxm_q <= '0;
    end else begin
      if (txm_wr_i) txm_q <= wdata_i;
      if (rxm_wr_i) rxm_q <= wdata_i;
    end
  end

  assign ctl_q_o = ctl_q;
  assign txm_q_o = txm_q;
  assign rxm_q_o = rxm_q;

  // R9: mode registers zero after any hold cycle
  a_r9_modes_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> (txm_q == '0 && rxm_q == '0));

  // R12: control write lands as written
  a_r12_ctl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && !gen_rst_i) |=> ctl_q == $past(ctl_wdata_i));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_stat_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_EVT-1:0]       evt_i,
  input  logic                   stat_rd_i,
  input  logic                   rxd_rd_i,
  input  logic                   txd_any_i,
  input  logic                   prog_wr_i,
  input  logic                   hold_i,
  input  logic                   fld_we_i,
  input  logic [FLD_W-1:0]       fld_i,
  output logic [FLAG_HI:FLAG_LO] flags_q_o,
  output logic [FLAG_HI:FLAG_LO] flags_d_o,
  output logic [FLD_W-1:0]       fld_q_o
);
  logic [FLAG_HI:FLAG_LO] q, d;
  logic [FLD_W-1:0]       fld_q;

  for (genvar gi = FLAG_LO; gi <= FLAG_HI; gi++) begin : g_flag
    localparam clr_src_e SRC = clr_src(gi);
    logic clr_b;
    if (SRC == CLR_ON_RXD)       begin : g_rxd  assign clr_b = rxd_rd_i;  end
    else if (SRC == CLR_ON_TXD)  begin : g_txd  assign clr_b = txd_any_i; end
    else if (SRC == CLR_ON_PROG) begin : g_prog assign clr_b = prog_wr_i; end
    else                         begin : g_stat assign clr_b = stat_rd_i; end

    // event beats clear; ring flag is outside the hold domain
    if (gi == RING_BIT) begin : g_keep
      assign d[gi] = evt_i[gi-FLAG_LO] | (q[gi] & ~clr_b);
    end else begin : g_held
      assign d[gi] = hold_i ? 1'b0 : (evt_i[gi-FLAG_LO] | (q[gi] & ~clr_b));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fld_q <= '0;
    else if (hold_i)   fld_q <= '0;
    else if (fld_we_i) fld_q <= fld_i;
  end

  assign flags_q_o = q;
  assign flags_d_o = d;
  assign fld_q_o   = fld_q;

  // R10: coincident event and clearing write leaves tx-ready set
  a_r10_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && evt_i[12-FLAG_LO] && txd_any_i) |=> q[12]);

  // R4: transmit-data write clears tx-ready
  a_r4_txd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_any_i && !evt_i[12-FLAG_LO]) |=> !q[12]);

  // R5: receive-data read clears overflow
  a_r5_rxd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxd_rd_i && !evt_i[5-FLAG_LO]) |=> !q[5]);

  // R9: hold clears everything but the ring flag
  a_r9_hold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (q[RING_BIT-1:FLAG_LO] == '0 && fld_q == '0));

  // R9: ring flag survives a hold
  a_r9_ring_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && q[RING_BIT] && !stat_rd_i) |=> q[RING_BIT]);
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_stat_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [FLAG_HI:FLAG_LO] flags_d_i,
  input  logic [N_MASK-1:0]      mask_i,
  input  logic                   stat_rd_i,
  input  logic                   hold_i,
  input  logic                   oe_i,
  output logic                   irq_q_o,
  output logic                   irq_n_o
);
  logic [FLAG_HI:FLAG_LO] hit;
  logic                   irq_q, irq_d;

  for (genvar gi = FLAG_LO; gi <= FLAG_HI; gi++) begin : g_hit
    assign hit[gi] = flags_d_i[gi] & mask_i[mask_sel(gi)];
  end

  assign irq_d = hold_i ? 1'b0 : ((|hit) | (irq_q & ~stat_rd_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_q_o = irq_q;
  // open-drain style pin
  assign irq_n_o = (irq_q & oe_i) ? 1'b0 : 1'bz;

  // R1: summary flag stays up until a status read
  a_r1_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !stat_rd_i && !hold_i) |=> irq_q);

  // R2: unmasked new flags cannot raise summary by themselves
  a_r2_no_mask_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_q && mask_i == '0) |=> !irq_q);
endmodule

// File: rtl/irq_stat_top.sv
module irq_stat_top
  import irq_stat_pkg::*;
#(
  parameter int DATA_W = STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gen_rst_i,
  input  logic              ctl_wr_i,
  input  logic              txm_wr_i,
  input  logic              rxm_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              stat_rd_i,
  input  logic              rxd_rd_i,
  input  logic              txd_wr_i,
  input  logic              txd_alt_wr_i,
  input  logic              prog_wr_i,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              fld_we_i,
  input  logic [FLD_W-1:0]  fld_i,
  output logic [DATA_W-1:0] ctl_o,
  output logic [DATA_W-1:0] txm_o,
  output logic [DATA_W-1:0] rxm_o,
  output logic [DATA_W-1:0] stat_o,
  output logic              irq_n_o
);
  logic [CTL_W-1:0]       ctl_q;
  logic                   hold;
  logic [FLAG_HI:FLAG_LO] flags_q, flags_d;
  logic [FLD_W-1:0]       fld_q;
  logic                   irq_q;

  irq_ctl_regs #(.DATA_W(DATA_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gen_rst_i   (gen_rst_i),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_wdata_i (wdata_i[CTL_W-1:0]),
    .txm_wr_i    (txm_wr_i),
    .rxm_wr_i    (rxm_wr_i),
    .wdata_i     (wdata_i),
    .ctl_q_o     (ctl_q),
    .txm_q_o     (txm_o),
    .rxm_q_o     (rxm_o),
    .hold_o      (hold)
  );

  irq_flag_bank u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .stat_rd_i (stat_rd_i),
    .rxd_rd_i  (rxd_rd_i),
    .txd_any_i (txd_wr_i | txd_alt_wr_i),
    .prog_wr_i (prog_wr_i),
    .hold_i    (hold),
    .fld_we_i  (fld_we_i),
    .fld_i     (fld_i),
    .flags_q_o (flags_q),
    .flags_d_o (flags_d),
    .fld_q_o   (fld_q)
  );

  irq_summary u_sum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flags_d_i (flags_d),
    .mask_i    (ctl_q[N_MASK-1:0]),
    .stat_rd_i (stat_rd_i),
    .hold_i    (hold),
    .oe_i      (ctl_q[OE_BIT]),
    .irq_q_o   (irq_q),
    .irq_n_o   (irq_n_o)
  );

  assign ctl_o  = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
  assign stat_o = {irq_q, flags_q, fld_q};

  // R8: field bits never reach the pin on their own
  a_r8_fields_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_q && flags_d == '0) |=> !irq_q);
endmodule

// File: tb/irq_stat_top_bench.sv
module irq_stat_top_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_ni = 1'b0;
  logic        gen_rst = 0, ctl_wr = 0, txm_wr = 0, rxm_wr = 0;
  logic [15:0] wdata = '0;
  logic        stat_rd = 0, rxd_rd = 0, txd_wr = 0, txd_alt = 0, prog_wr = 0;
  logic [9:0]  evt = '0;
  logic        fld_we = 0;
  logic [4:0]  fld = '0;
  logic [15:0] ctl_o, txm_o, rxm_o, stat_o;
  logic        irq_n;

  irq_stat_top u_irq_stat_top (
    .clk_i(clk), .rst_ni(rst_ni), .gen_rst_i(gen_rst), .ctl_wr_i(ctl_wr),
    .txm_wr_i(txm_wr), .rxm_wr_i(rxm_wr), .wdata_i(wdata), .stat_rd_i(stat_rd),
    .rxd_rd_i(rxd_rd), .txd_wr_i(txd_wr), .txd_alt_wr_i(txd_alt),
    .prog_wr_i(prog_wr), .evt_i(evt), .fld_we_i(fld_we), .fld_i(fld),
    .ctl_o(ctl_o), .txm_o(txm_o), .rxm_o(rxm_o), .stat_o(stat_o), .irq_n_o(irq_n)
  );

  typedef struct {
    int          sel;   // 0 stat 1 ctl 2 txm 3 rxm 4 pin (1 = high-z, 0 = low)
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q_exp[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  task automatic ex(input int sel, input logic [15:0] v, input string tag);
    item_t it;
    it.sel = sel; it.exp = v; it.tag = tag;
    q_exp.push_back(it);
  endtask

  // monitor: compares queued expectations one half-cycle after the edge
  always @(negedge clk) begin
    while (q_exp.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q_exp.pop_front();
      case (it.sel)
        0: act = stat_o;
        1: act = ctl_o;
        2: act = txm_o;
        3: act = rxm_o;
        default: act = (irq_n === 1'bz) ? 16'd1 : ((irq_n === 1'b0) ? 16'd0 : 16'hFFFF);
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic sync();
    @(negedge clk);
  endtask

  task automatic go();
    @(posedge clk);
    #1;
    gen_rst = 0; ctl_wr = 0; txm_wr = 0; rxm_wr = 0; stat_rd = 0; rxd_rd = 0;
    txd_wr = 0; txd_alt = 0; prog_wr = 0; evt = '0; fld_we = 0;
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    sync(); ctl_wr = 1; wdata = v; go();
  endtask

  task automatic idle();
    sync(); go();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    sync(); rst_ni = 1'b1;
    idle();
    ex(0, 16'h0000, "R9 reset status");
    ex(1, 16'h0000, "R12 reset control");
    ex(4, 16'd1, "R3 reset pin high-z");

    wr_ctl(16'hFE7F); ex(1, 16'h007F, "R12 upper control bits read 0");
    wr_ctl(16'h017F); ex(1, 16'h017F, "R12 control readback");
    sync(); txm_wr = 1; wdata = 16'hA5C3; go(); ex(2, 16'hA5C3, "R9 txm write");
    sync(); rxm_wr = 1; wdata = 16'h1234; go(); ex(3, 16'h1234, "R9 rxm write");

    // tx ready (lane 7 -> bit 12), mask 3
    sync(); evt = 10'h080; go();
    ex(0, 16'h9000, "R1 tx ready raises summary"); ex(4, 16'd0, "R3 pin low");
    sync(); stat_rd = 1; go(); ex(0, 16'h9000, "R4 status read keeps tx ready");
    sync(); txd_alt = 1; go(); ex(0, 16'h8000, "R4 alternate tx write clears");
    sync(); stat_rd = 1; go(); ex(0, 16'h0000, "R1 status read clears summary");
    ex(4, 16'd1, "R3 pin released");

    // underflow (lane 6 -> bit 11) with coincident tx write
    sync(); evt = 10'h040; txd_wr = 1; go(); ex(0, 16'h8800, "R10 event beats clear");
    sync(); txd_wr = 1; go(); ex(0, 16'h8000, "R4 tx write clears underflow");
    sync(); stat_rd = 1; go(); ex(0, 16'h0000, "R1 cleared");

    // masks off, then enable mask 0 with rx ready already set
    wr_ctl(16'h0140);
    sync(); evt = 10'h002; go(); ex(0, 16'h0040, "R2 unmasked flag no summary");
    ex(4, 16'd1, "R2 pin stays high-z");
    wr_ctl(16'h0141); ex(0, 16'h0040, "R11 summary not yet");
    idle(); ex(0, 16'h8040, "R11 late mask raises summary"); ex(4, 16'd0, "R11 pin low");
    sync(); stat_rd = 1; go(); ex(0, 16'h8040, "R5 status read keeps rx ready");
    sync(); rxd_rd = 1; go(); ex(0, 16'h8000, "R5 rx read clears ready");
    sync(); stat_rd = 1; go(); ex(0, 16'h0000, "R1 cleared");

    // ring and detector bits, masks 1,2,5 off
    sync(); evt = 10'h200; go(); ex(0, 16'h4000, "R2 ring unmasked");
    sync(); stat_rd = 1; go(); ex(0, 16'h0000, "R6 status read clears ring");
    sync(); evt = 10'h03C; go(); ex(0, 16'h0780, "R2 detector bits unmasked");
    sync(); stat_rd = 1; go(); ex(0, 16'h0000, "R6 status read clears bits 10..7");

    // overflow (lane 0 -> bit 5)
    sync(); evt = 10'h001; go(); ex(0, 16'h8020, "R2 overflow under mask 0");
    sync(); stat_rd = 1; go(); ex(0, 16'h8020, "R5 status read keeps overflow");
    sync(); rxd_rd = 1; go(); ex(0, 16'h8000, "R5 rx read clears overflow");
    sync(); stat_rd = 1; go(); ex(0, 16'h0000, "R1 cleared");

    // programming done (lane 8 -> bit 13)
    sync(); evt = 10'h100; go(); ex(0, 16'h2000, "R7 prog done set");
    sync(); stat_rd = 1; go(); ex(0, 16'h2000, "R7 status read keeps prog done");
    sync(); prog_wr = 1; go(); ex(0, 16'h0000, "R7 prog write clears");

    // fields with all masks on
    wr_ctl(16'h017F);
    sync(); fld_we = 1; fld = 5'h1F; go(); ex(0, 16'h001F, "R8 fields load no summary");
    ex(4, 16'd1, "R8 pin high-z");
    sync(); stat_rd = 1; go(); ex(0, 16'h001F, "R8 fields hold");

    // soft reset hold
    sync(); evt = 10'h280; go(); ex(0, 16'hD01F, "R1 ring and tx ready");
    wr_ctl(16'h01FF); ex(0, 16'hD01F, "R9 hold not yet active");
    idle(); ex(0, 16'h4000, "R9 hold clears all but ring");
    ex(2, 16'h0000, "R9 txm cleared"); ex(3, 16'h0000, "R9 rxm cleared");
    ex(4, 16'd1, "R9 pin released in hold");
    wr_ctl(16'h017F); ex(0, 16'h4000, "R9 still held");
    idle(); ex(0, 16'hC000, "R9 ring raises summary after hold");
    sync(); stat_rd = 1; go(); ex(0, 16'h0000, "R6 ring cleared");

    // general reset
    sync(); txm_wr = 1; wdata = 16'h00FF; evt = 10'h080; go();
    ex(0, 16'h9000, "R1 tx ready again");
    sync(); gen_rst = 1; go();
    ex(0, 16'h0000, "R9 general reset status"); ex(1, 16'h0000, "R12 general reset control");
    ex(2, 16'h0000, "R9 general reset txm"); ex(4, 16'd1, "R9 general reset pin");

    // pin enable off
    wr_ctl(16'h013F);
    sync(); evt = 10'h080; go(); ex(0, 16'h9000, "R3 summary with pin disabled");
    ex(4, 16'd1, "R3 pin high-z when disabled");

    idle(); idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule